// File: doc/BRIEF.md
# Indirect Register Access Bridge

The bridge sits behind a management-bus slave port and gives a host access to an internal register space of 32 devices by 32 registers, each 16 bits wide. The host-side port is a simple parallel access: a one-cycle valid strobe with a device address, a register address, a write flag and write data. Every access the bridge accepts is answered one cycle later with a done pulse and read data. A separate request/acknowledge port leads to the internal register bank.

The bridge has two modes, chosen by a five-bit strap input. With the strap at zero, the bridge works in direct mode: each bus access is passed straight to the bank at the device and register it names. With a nonzero strap, it answers only accesses aimed at the strap device. That device has two registers. Register 0 is a command register, holding a start/busy flag, a valid bit, an operation code and the target device and register fields. Register 1 is a data register: it holds write data going to the bank and read results coming back.

A launched operation keeps the busy flag set until the bank acknowledges it. If no acknowledge arrives within a bounded number of cycles, the operation is aborted. This lets a host that polls only a fixed number of times always see busy clear.

Top module: `mib_bridge`

## Requirements
- R1: After reset, the command register reads 0x0000, the data register reads 0x0000, and `bank_req_o` and `bus_done_o` are low.
- R2: With a nonzero strap, writing command value 0x9800 | dev<<5 | reg to register 0 sets the busy flag and issues one bank read of (dev, reg). When the bank acknowledges, its data is stored in the data register, where register 1 returns it.
- R3: Command value 0x9400 | dev<<5 | reg issues one bank write of (dev, reg). The write data is the value held in the data register (register 1) at launch.
- R4: While an operation is pending, the command register reads back bit 15 set and bits 14:0 as written. Bit 15 reads 0 from the cycle after the bank acknowledge. With acknowledge delays up to 7 cycles, a host sees busy clear within 16 polls.
- R5: A command is valid only when bit 12 is 1 and bits 11:10 are 2'b10 (read) or 2'b01 (write). Any other command sets busy for one cycle and then clears it, without a bank request.
- R6: A write to the command register while busy is set is ignored. The pending operation keeps its target, and the command register keeps its value.
- R7: If the bank gives no acknowledge within WAIT_LIMIT cycles of the request (default 12), the operation ends and busy clears. A read that ends this way leaves 0xFFFF in the data register.
- R8: With a nonzero strap, an access to any other device address gets no done pulse and causes no bank request.
- R9: With the strap at zero, each bus access issues a bank access to the bus device and register. Its done pulse and read data appear on the cycle after the acknowledge. Accesses made while one is pending are dropped.
- R10: `bank_req_o` is a single-cycle pulse per operation.
- R11: In indirect mode, every access to the strap device is answered with `bus_done_o` on the next cycle. Registers other than 0 and 1 read as 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| strap_addr_i | input | 5 | Strap device address; zero selects direct mode |
| bus_valid_i | input | 1 | Bus access strobe |
| bus_we_i | input | 1 | Bus write flag |
| bus_dev_i | input | 5 | Bus device address |
| bus_reg_i | input | 5 | Bus register address |
| bus_wdata_i | input | 16 | Bus write data |
| bus_done_o | output | 1 | Access answered pulse |
| bus_rdata_o | output | 16 | Read data, valid with done |
| bank_req_o | output | 1 | Bank request pulse |
| bank_we_o | output | 1 | Bank write flag |
| bank_dev_o | output | 5 | Bank device address |
| bank_reg_o | output | 5 | Bank register address |
| bank_wdata_o | output | 16 | Bank write data |
| bank_ack_i | input | 1 | Bank acknowledge |
| bank_rdata_i | input | 16 | Bank read data, valid with acknowledge |

## Verification
In indirect mode, a register access strobed in cycle T has its done pulse and data in cycle T+1. A launched command raises `bank_req_o` in T+1, and busy reads clear from the cycle after the acknowledge. The bench drives each strobe for one cycle from a falling edge and reads the answer at the next falling edge. It then follows busy by polling, so the acknowledge delay of its bank model can vary from 0 to 7 cycles without changing the checks. In direct mode, the done pulse arrives a data-dependent number of cycles later, so the bench waits at falling edges for it up to a fixed bound. The timeout case is bounded by WAIT_LIMIT+1 cycles of busy.

// File: rtl/mib_pkg.sv
package mib_pkg;
  localparam int unsigned ADDR_W = 5;
  localparam int unsigned DATA_W = 16;

  typedef enum logic [1:0] {
    OP_NONE = 2'b00,
    OP_WR   = 2'b01,
    OP_RD   = 2'b10,
    OP_BAD  = 2'b11
  } op_e;

  typedef struct packed {
    logic              start;
    logic [1:0]        rsvd;
    logic              valid;
    op_e               op;
    logic [ADDR_W-1:0] dev;
    logic [ADDR_W-1:0] regn;
  } cmd_t;

  localparam logic [ADDR_W-1:0] REG_CMD  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] REG_DATA = ADDR_W'(1);
endpackage

// File: rtl/mib_cmd_dec.sv
module mib_cmd_dec
  import mib_pkg::*;
(
  input  cmd_t cmd_i,
  output logic launch_o,
  output logic we_o
);
  always_comb begin
    launch_o = 1'b0;
    we_o     = 1'b0;
    if (cmd_i.valid) begin
      unique case (cmd_i.op)
        OP_RD:   launch_o = 1'b1;
        OP_WR: begin
          launch_o = 1'b1;
          we_o     = 1'b1;
        end
        default: launch_o = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/mib_bank_seq.sv
module mib_bank_seq
  import mib_pkg::*;
#(
  parameter int unsigned WAIT_LIMIT = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] dev_i,
  input  logic [ADDR_W-1:0] reg_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              active_o,
  output logic              fin_o,
  output logic              timeout_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              bank_req_o,
  output logic              bank_we_o,
  output logic [ADDR_W-1:0] bank_dev_o,
  output logic [ADDR_W-1:0] bank_reg_o,
  output logic [DATA_W-1:0] bank_wdata_o,
  input  logic              bank_ack_i,
  input  logic [DATA_W-1:0] bank_rdata_i
);
  localparam int unsigned CNT_W = $clog2(WAIT_LIMIT + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WAIT_LIMIT - 1);

  logic              active_q, req_q, we_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [ADDR_W-1:0] dev_q, reg_q;
  logic [DATA_W-1:0] wdata_q;

  assign fin_o     = active_q && (bank_ack_i || cnt_q == CNT_LAST);
  assign timeout_o = fin_o && !bank_ack_i;
  assign rdata_o   = bank_ack_i ? bank_rdata_i : '1;
  assign active_o  = active_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      req_q    <= 1'b0;
      we_q     <= 1'b0;
      cnt_q    <= '0;
      dev_q    <= '0;
      reg_q    <= '0;
      wdata_q  <= '0;
    end else begin
      req_q <= 1'b0;
      if (start_i && !active_q) begin
        active_q <= 1'b1;
        req_q    <= 1'b1;
        cnt_q    <= '0;
        we_q     <= we_i;
        dev_q    <= dev_i;
        reg_q    <= reg_i;
        wdata_q  <= wdata_i;
      end else if (active_q) begin
        if (fin_o) active_q <= 1'b0;
        else       cnt_q    <= cnt_q + 1'b1;
      end
    end
  end

  assign bank_req_o   = req_q;
  assign bank_we_o    = we_q;
  assign bank_dev_o   = dev_q;
  assign bank_reg_o   = reg_q;
  assign bank_wdata_o = wdata_q;
endmodule

// File: rtl/mib_bridge.sv
module mib_bridge
  import mib_pkg::*;
#(
  parameter int unsigned WAIT_LIMIT = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [4:0]        strap_addr_i,
  input  logic              bus_valid_i,
  input  logic              bus_we_i,
  input  logic [4:0]        bus_dev_i,
  input  logic [4:0]        bus_reg_i,
  input  logic [15:0]       bus_wdata_i,
  output logic              bus_done_o,
  output logic [15:0]       bus_rdata_o,
  output logic              bank_req_o,
  output logic              bank_we_o,
  output logic [4:0]        bank_dev_o,
  output logic [4:0]        bank_reg_o,
  output logic [15:0]       bank_wdata_o,
  input  logic              bank_ack_i,
  input  logic [15:0]       bank_rdata_i
);
  logic indirect, hit, cmd_wr, data_wr, accept;
  logic busy_q, noop_q, done_q;
  cmd_t cmd_q, cmd_new;
  logic [DATA_W-1:0] data_q, rdata_q, rd_mux;
  logic dec_launch, dec_we;
  logic seq_start, seq_we, seq_active, seq_fin, seq_timeout;
  logic [ADDR_W-1:0] seq_dev, seq_reg;
  logic [DATA_W-1:0] seq_wdata, seq_rdata;

  assign indirect = |strap_addr_i;
  assign hit      = indirect && bus_valid_i && (bus_dev_i == strap_addr_i);
  assign cmd_wr   = hit && bus_we_i && (bus_reg_i == REG_CMD);
  assign data_wr  = hit && bus_we_i && (bus_reg_i == REG_DATA);
  assign accept   = cmd_wr && !busy_q;
  assign cmd_new  = cmd_t'(bus_wdata_i);

  mib_cmd_dec u_dec (
    .cmd_i    (cmd_new),
    .launch_o (dec_launch),
    .we_o     (dec_we)
  );

  // direct mode forwards the bus fields, indirect mode the command fields
  always_comb begin
    if (indirect) begin
      seq_start = accept && dec_launch;
      seq_we    = dec_we;
      seq_dev   = cmd_new.dev;
      seq_reg   = cmd_new.regn;
      seq_wdata = data_q;
    end else begin
      seq_start = bus_valid_i && !seq_active;
      seq_we    = bus_we_i;
      seq_dev   = bus_dev_i;
      seq_reg   = bus_reg_i;
      seq_wdata = bus_wdata_i;
    end
  end

  mib_bank_seq #(.WAIT_LIMIT(WAIT_LIMIT)) u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (seq_start),
    .we_i         (seq_we),
    .dev_i        (seq_dev),
    .reg_i        (seq_reg),
    .wdata_i      (seq_wdata),
    .active_o     (seq_active),
    .fin_o        (seq_fin),
    .timeout_o    (seq_timeout),
    .rdata_o      (seq_rdata),
    .bank_req_o   (bank_req_o),
    .bank_we_o    (bank_we_o),
    .bank_dev_o   (bank_dev_o),
    .bank_reg_o   (bank_reg_o),
    .bank_wdata_o (bank_wdata_o),
    .bank_ack_i   (bank_ack_i),
    .bank_rdata_i (bank_rdata_i)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      noop_q <= 1'b0;
      cmd_q  <= '0;
    end else if (accept) begin
      busy_q <= 1'b1;
      noop_q <= !dec_launch;
      cmd_q  <= cmd_new;
    end else if (noop_q || (indirect && seq_fin)) begin
      busy_q <= 1'b0;
      noop_q <= 1'b0;
    end
  end

  // a completing read takes priority over a same-cycle host data write
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
    end else if (indirect && seq_fin && busy_q && cmd_q.op == OP_RD) begin
      data_q <= seq_rdata;
    end else if (data_wr) begin
      data_q <= bus_wdata_i;
    end
  end

  always_comb begin
    unique case (bus_reg_i)
      REG_CMD:  rd_mux = {busy_q, cmd_q[DATA_W-2:0]};
      REG_DATA: rd_mux = data_q;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q  <= 1'b0;
      rdata_q <= '0;
    end else if (indirect) begin
      done_q  <= hit;
      rdata_q <= (hit && !bus_we_i) ? rd_mux : '0;
    end else begin
      done_q  <= seq_fin;
      rdata_q <= seq_fin ? seq_rdata : '0;
    end
  end

  assign bus_done_o  = done_q;
  assign bus_rdata_o = rdata_q;

  logic unused_ok;
  assign unused_ok = seq_timeout;
endmodule

// File: rtl/mib_bridge_chk.sv
module mib_bridge_chk #(
  parameter int unsigned WAIT_LIMIT = 12
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [4:0]  strap_addr_i,
  input logic        bus_valid_i,
  input logic [4:0]  bus_dev_i,
  input logic        bus_done_o,
  input logic        bank_req_o,
  input logic        bank_ack_i,
  input logic        busy_q,
  input logic        cmd_wr,
  input logic [15:0] cmd_q,
  input logic        seq_active
);
  logic [7:0] busy_run;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) busy_run <= '0;
    else if (busy_q) busy_run <= busy_run + 1'b1;
    else busy_run <= '0;
  end

  AST_REQ_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bank_req_o |=> !bank_req_o); // R10

  AST_BUSY_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_run <= 8'(WAIT_LIMIT + 1)); // R7

  AST_FOREIGN_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_valid_i && strap_addr_i != 5'd0 && bus_dev_i != strap_addr_i) |=> !bus_done_o); // R8

  AST_CMD_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && cmd_wr) |=> $stable(cmd_q)); // R6

  AST_REQ_WHEN_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strap_addr_i != 5'd0 && bank_req_o) |-> busy_q); // R2

  AST_ACK_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strap_addr_i != 5'd0 && seq_active && bank_ack_i) |=> !busy_q); // R4
endmodule

bind mib_bridge mib_bridge_chk #(.WAIT_LIMIT(WAIT_LIMIT)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .strap_addr_i (strap_addr_i),
  .bus_valid_i  (bus_valid_i),
  .bus_dev_i    (bus_dev_i),
  .bus_done_o   (bus_done_o),
  .bank_req_o   (bank_req_o),
  .bank_ack_i   (bank_ack_i),
  .busy_q       (busy_q),
  .cmd_wr       (cmd_wr),
  .cmd_q        (cmd_q),
  .seq_active   (seq_active)
);

// File: tb/mib_bridge_bench.sv
module mib_bridge_bench;
  localparam logic [4:0] STRAP = 5'd5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [4:0] strap = STRAP;
  logic bus_valid = 1'b0, bus_we = 1'b0;
  logic [4:0] bus_dev = '0, bus_reg = '0;
  logic [15:0] bus_wdata = '0;
  logic bus_done;
  logic [15:0] bus_rdata;
  logic bank_req, bank_we;
  logic [4:0] bank_dev, bank_reg;
  logic [15:0] bank_wdata;
  logic bank_ack;
  logic [15:0] bank_rdata;

  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  mib_bridge u_mib_bridge (
    .clk_i(clk), .rst_ni(rst_n), .strap_addr_i(strap),
    .bus_valid_i(bus_valid), .bus_we_i(bus_we), .bus_dev_i(bus_dev),
    .bus_reg_i(bus_reg), .bus_wdata_i(bus_wdata),
    .bus_done_o(bus_done), .bus_rdata_o(bus_rdata),
    .bank_req_o(bank_req), .bank_we_o(bank_we), .bank_dev_o(bank_dev),
    .bank_reg_o(bank_reg), .bank_wdata_o(bank_wdata),
    .bank_ack_i(bank_ack), .bank_rdata_i(bank_rdata)
  );

  // bank model
  logic [15:0] mem [1024];
  int ack_delay = 0;
  logic ack_en = 1'b1;
  int req_count = 0;
  logic pend = 1'b0;
  int cnt = 0;
  logic m_we = 1'b0;
  logic [9:0] m_idx = '0;
  logic [15:0] m_wd = '0;
  logic [4:0] last_dev = '0, last_reg = '0;
  logic last_we = 1'b0;
  logic [15:0] last_wd = '0;

  initial for (int i = 0; i < 1024; i++) mem[i] = 16'(i * 37) ^ 16'hA5C3;

  always @(posedge clk) begin
    bank_ack <= 1'b0;
    if (bank_req) begin
      req_count <= req_count + 1;
      pend <= 1'b1; cnt <= ack_delay;
      m_we <= bank_we; m_idx <= {bank_dev, bank_reg}; m_wd <= bank_wdata;
      last_dev <= bank_dev; last_reg <= bank_reg; last_we <= bank_we; last_wd <= bank_wdata;
    end else if (pend && ack_en) begin
      if (cnt == 0) begin
        bank_ack <= 1'b1;
        bank_rdata <= mem[m_idx];
        if (m_we) mem[m_idx] <= m_wd;
        pend <= 1'b0;
      end else cnt <= cnt - 1;
    end
  end
  initial bank_ack = 1'b0;
  initial bank_rdata = '0;

  task automatic chk(input logic ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_acc(input logic we, input logic [4:0] dev, input logic [4:0] rg,
                         input logic [15:0] wd, output logic done, output logic [15:0] rd);
    @(negedge clk);
    bus_valid = 1'b1; bus_we = we; bus_dev = dev; bus_reg = rg; bus_wdata = wd;
    @(negedge clk);
    bus_valid = 1'b0;
    done = bus_done; rd = bus_rdata;
  endtask

  task automatic poll_idle(output int polls, output logic [15:0] first);
    logic d; logic [15:0] rd;
    polls = 0; first = '0;
    for (int p = 0; p < 16; p++) begin
      bus_acc(1'b0, STRAP, 5'd0, 16'h0, d, rd);
      polls++;
      if (p == 0) first = rd;
      if (!rd[15]) break;
    end
  endtask

  task automatic do_reset(input logic [4:0] s);
    @(negedge clk); rst_n = 1'b0; strap = s;
    repeat (2) @(negedge clk); rst_n = 1'b1;
  endtask

  // {we, dev, reg, wdata, delay, expected read}
  localparam int NV = 8;
  localparam logic [45:0] VEC [NV] = '{
    {1'b1, 5'd3,  5'd4,  16'h1234, 3'd0, 16'h0000},
    {1'b0, 5'd3,  5'd4,  16'h0000, 3'd2, 16'h1234},
    {1'b1, 5'd31, 5'd31, 16'hBEEF, 3'd5, 16'h0000},
    {1'b0, 5'd31, 5'd31, 16'h0000, 3'd7, 16'hBEEF},
    {1'b1, 5'd0,  5'd0,  16'h0001, 3'd1, 16'h0000},
    {1'b0, 5'd0,  5'd0,  16'h0000, 3'd0, 16'h0001},
    {1'b1, 5'd16, 5'd1,  16'hFFFF, 3'd3, 16'h0000},
    {1'b0, 5'd16, 5'd1,  16'h0000, 3'd4, 16'hFFFF}
  };

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic d; logic [15:0] rd, first; int polls, rc0;
    do_reset(STRAP);

    // R1 reset state
    chk(!bus_done && !bank_req, "R1 outputs idle", {14'b0, bus_done, bank_req}, 16'h0);
    bus_acc(1'b0, STRAP, 5'd0, 16'h0, d, rd);
    chk(d && rd == 16'h0000, "R1 cmd reset", rd, 16'h0000);
    bus_acc(1'b0, STRAP, 5'd1, 16'h0, d, rd);
    chk(d && rd == 16'h0000, "R1 data reset", rd, 16'h0000);

    // R2/R3/R4 table walk
    for (int v = 0; v < NV; v++) begin
      logic w; logic [4:0] dv, rg; logic [15:0] wd, ex, cmd;
      {w, dv, rg, wd} = VEC[v][45:19];
      ack_delay = int'(VEC[v][18:16]);
      ex = VEC[v][15:0];
      cmd = (w ? 16'h9400 : 16'h9800) | {6'b0, dv, rg};
      rc0 = req_count;
      if (w) bus_acc(1'b1, STRAP, 5'd1, wd, d, rd);
      bus_acc(1'b1, STRAP, 5'd0, cmd, d, rd);
      poll_idle(polls, first);
      chk(first == cmd, "R4 busy readback", first, cmd);
      chk(polls < 16, "R4 poll bound", 16'(polls), 16'd15);
      chk(req_count == rc0 + 1 && last_dev == dv && last_reg == rg && last_we == w,
          w ? "R3 bank write target" : "R2 bank read target",
          {1'b0, last_we, last_dev, last_reg, 4'(req_count - rc0)}, {1'b0, w, dv, rg, 4'd1});
      if (w) chk(last_wd == wd, "R3 write data", last_wd, wd);
      else begin
        bus_acc(1'b0, STRAP, 5'd1, 16'h0, d, rd);
        chk(d && rd == ex, "R2 read result", rd, ex);
      end
    end
    chk(mem[{5'd31, 5'd31}] == 16'hBEEF, "R3 bank content", mem[{5'd31, 5'd31}], 16'hBEEF);

    // R5 invalid commands
    begin
      logic [15:0] bad [3] = '{16'h8864, 16'h9C64, 16'h9064};
      for (int b = 0; b < 3; b++) begin
        rc0 = req_count;
        bus_acc(1'b1, STRAP, 5'd0, bad[b], d, rd);
        bus_acc(1'b0, STRAP, 5'd0, 16'h0, d, rd);
        bus_acc(1'b0, STRAP, 5'd0, 16'h0, d, rd);
        chk(rd == {1'b0, bad[b][14:0]}, "R5 busy cleared", rd, {1'b0, bad[b][14:0]});
        chk(req_count == rc0, "R5 no request", 16'(req_count - rc0), 16'd0);
      end
    end

    // R6 command write while busy
    ack_delay = 6;
    rc0 = req_count;
    bus_acc(1'b1, STRAP, 5'd0, 16'h9822, d, rd);
    bus_acc(1'b1, STRAP, 5'd0, 16'h9529, d, rd);
    bus_acc(1'b0, STRAP, 5'd0, 16'h0, d, rd);
    chk(rd == 16'h9822, "R6 cmd held", rd, 16'h9822);
    poll_idle(polls, first);
    chk(req_count == rc0 + 1 && last_dev == 5'd1 && last_reg == 5'd2 && !last_we,
        "R6 pending op kept", {6'b0, last_dev, last_reg}, {6'b0, 5'd1, 5'd2});

    // R7 timeout
    ack_en = 1'b0;
    bus_acc(1'b1, STRAP, 5'd0, 16'h98A7, d, rd);
    poll_idle(polls, first);
    chk(first[15] && polls < 16, "R7 busy clears on timeout", 16'(polls), 16'd8);
    bus_acc(1'b0, STRAP, 5'd1, 16'h0, d, rd);
    chk(rd == 16'hFFFF, "R7 timeout read data", rd, 16'hFFFF);
    ack_en = 1'b1;
    repeat (3) @(negedge clk);

    // R8 foreign device, R11 other registers
    rc0 = req_count;
    bus_acc(1'b1, 5'd6, 5'd0, 16'h9800, d, rd);
    chk(!d, "R8 foreign write silent", {15'b0, d}, 16'h0);
    bus_acc(1'b0, 5'd6, 5'd1, 16'h0, d, rd);
    chk(!d && req_count == rc0, "R8 foreign read silent", 16'(req_count - rc0), 16'h0);
    bus_acc(1'b0, STRAP, 5'd3, 16'h0, d, rd);
    chk(d && rd == 16'h0000, "R11 unused register", rd, 16'h0000);
    bus_acc(1'b1, STRAP, 5'd9, 16'h7777, d, rd);
    chk(d, "R11 write answered", {15'b0, d}, 16'h1);

    // R9 direct mode
    do_reset(5'd0);
    ack_delay = 2;
    begin
      logic got; logic [15:0] val;
      // write dev 12 reg 6
      @(negedge clk);
      bus_valid = 1'b1; bus_we = 1'b1; bus_dev = 5'd12; bus_reg = 5'd6; bus_wdata = 16'h5A5A;
      @(negedge clk); bus_valid = 1'b0;
      got = 1'b0;
      for (int k = 0; k < 20 && !got; k++) begin
        if (bus_done) got = 1'b1; else @(negedge clk);
      end
      chk(got && last_we && last_dev == 5'd12 && last_reg == 5'd6, "R9 direct write",
          {6'b0, last_dev, last_reg}, {6'b0, 5'd12, 5'd6});
      // read dev 3 reg 4 with a second access dropped while pending
      rc0 = req_count;
      ack_delay = 4;
      @(negedge clk);
      bus_valid = 1'b1; bus_we = 1'b0; bus_dev = 5'd3; bus_reg = 5'd4;
      @(negedge clk); bus_dev = 5'd9; bus_reg = 5'd9;
      @(negedge clk); bus_valid = 1'b0;
      got = 1'b0; val = '0;
      for (int k = 0; k < 20 && !got; k++) begin
        if (bus_done) begin got = 1'b1; val = bus_rdata; end else @(negedge clk);
      end
      chk(got && val == 16'h1234, "R9 direct read", val, 16'h1234);
      chk(req_count == rc0 + 1, "R9 pending drop", 16'(req_count - rc0), 16'd1);
      chk(mem[{5'd12, 5'd6}] == 16'h5A5A, "R9 direct bank content", mem[{5'd12, 5'd6}], 16'h5A5A);
    end

    // R10 single-cycle request
    ack_delay = 0;
    @(negedge clk);
    bus_valid = 1'b1; bus_we = 1'b0; bus_dev = 5'd1; bus_reg = 5'd1;
    @(negedge clk); bus_valid = 1'b0;
    chk(bank_req, "R10 request high", {15'b0, bank_req}, 16'h1);
    @(negedge clk);
    chk(!bank_req, "R10 request drops", {15'b0, bank_req}, 16'h0);
    repeat (4) @(negedge clk);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule